// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital controller of a two-input, 8-bit successive-approximation converter that is read over a three-wire serial link. A falling edge on the asynchronous start input wakes the analog section, holds an acquisition window and then runs eight bit trials. Each trial offers a code to the capacitive DAC and keeps or clears the trial bit from the comparator decision. The finished code stays in a static register, and the analog section is switched off again without any command.

The start input also selects the channel. A single falling edge converts input 0. A further falling edge while a conversion is running abandons it and starts again on input 1. The selection returns to input 0 only after a complete 8-bit readout. The serial output is low while a conversion runs. It shows the MSB as soon as the result is ready and steps one bit lower on each serial clock falling edge that follows a rising edge. The serial clock may rest high or low. After the eighth rising edge the output is released to high impedance.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, sdo_oe_o, pwr_en_o and ch_sel_o are 0, and dac_code_o is 8'h00.
- R2: A high-to-low transition of cnvst_i raises pwr_en_o, drives sdo_oe_o=1 with sdo_o=0, and keeps ch_sel_o at its current value. The outputs change on the third clk edge after the transition, counting the edge that first samples it.
- R3: A cnvst_i falling edge seen while pwr_en_o=1 sets ch_sel_o=1 and restarts the full acquisition-plus-conversion time of ACQ_CYC+8*BIT_CYC cycles. If this edge lands on the final cycle of the last bit trial, the restart still wins.
- R4: While pwr_en_o=1, sdo_o is 0 with sdo_oe_o=1, and sclk_i edges have no effect on the later readout.
- R5: Each conversion starts with dac_code_o=8'h80. For bit 7 down to bit 0, each trial lasts BIT_CYC cycles and keeps its bit when cmp_ge_i=1. The final code is the largest value not above the input, in straight binary, and full scale is 8'hFF.
- R6: In the cycle pwr_en_o falls, sdo_o already carries bit 7 of the result. The result then stays unchanged on dac_code_o for any time until the next conversion starts.
- R7: During readout, a synchronised sclk_i falling edge moves sdo_o to the next lower bit only if a rising edge came after the previous move. This gives MSB-first data with sclk_i resting either low or high.
- R8: The eighth sclk_i rising edge of a readout drops sdo_oe_o, and only this event returns ch_sel_o to 0.
- R9: If cnvst_i is already low when reset ends, no conversion starts, and a later low-to-high change alone starts none.
- R10: A cnvst_i falling edge during an unfinished readout abandons it and converts again on the unchanged channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal conversion clock |
| rst_n | input | 1 | Active-low reset |
| cnvst_i | input | 1 | Asynchronous convert/start; falling edge starts or restarts |
| sclk_i | input | 1 | Asynchronous serial read clock |
| cmp_ge_i | input | 1 | Comparator: 1 when the held input is at least the DAC level |
| dac_code_o | output | RES_W | Trial code during conversion, held result afterwards |
| ch_sel_o | output | 1 | Multiplexer select, 0 = input 0, 1 = input 1 |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data drive enable; 0 means high impedance |
| pwr_en_o | output | 1 | Analog section power enable |

## Verification
The most delicate overlap is a start edge arriving in the very cycle the last bit trial would finish the conversion. The bench provokes it by placing the second cnvst_i fall exactly ACQ_CYC+8*BIT_CYC clocks after the first. It expects pwr_en_o never to drop and ch_sel_o to rise, so that the result read later comes from input 1. A behavioural model, advanced on every clock, judges the same collision cycle by cycle, along with start edges landing in a pending readout.

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int ACQ_CYC = 16,
  parameter int BIT_CYC = 4,
  parameter int RES_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnvst_i,
  input  logic             sclk_i,
  input  logic             cmp_ge_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             ch_sel_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             pwr_en_o
);
  localparam int CNT_MAX = (ACQ_CYC > BIT_CYC) ? ACQ_CYC : BIT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int IDX_W   = $clog2(RES_W);
  localparam int RCNT_W  = $clog2(RES_W + 1);
  localparam logic [RES_W-1:0] MID_CODE = {1'b1, {(RES_W-1){1'b0}}};

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV, ST_READ} st_t;

  st_t              st;
  logic [2:0]       cv_q, sk_q;
  logic [CNT_W-1:0] tcnt;
  logic [IDX_W-1:0] bidx;
  logic [RCNT_W-1:0] rcnt;
  logic [RES_W-1:0] sar, sar_nxt;
  logic             ch, armed;
  logic             cv_fall, sk_rise, sk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= '0;
      sk_q <= '0;
    end else begin
      cv_q <= {cv_q[1:0], cnvst_i};
      sk_q <= {sk_q[1:0], sclk_i};
    end
  end

  assign cv_fall = cv_q[2] & ~cv_q[1];
  assign sk_rise = ~sk_q[2] & sk_q[1];
  assign sk_fall = sk_q[2] & ~sk_q[1];

  always_comb begin
    sar_nxt = sar;
    if (!cmp_ge_i) sar_nxt[bidx] = 1'b0;
    if (bidx != '0) sar_nxt[bidx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      tcnt  <= '0;
      bidx  <= IDX_W'(RES_W - 1);
      rcnt  <= '0;
      sar   <= '0;
      ch    <= 1'b0;
      armed <= 1'b0;
    end else if (cv_fall) begin
      st   <= ST_ACQ;
      tcnt <= '0;
      sar  <= MID_CODE;
      if (st == ST_ACQ || st == ST_CONV) ch <= 1'b1;
    end else begin
      case (st)
        ST_ACQ: begin
          if (tcnt == CNT_W'(ACQ_CYC - 1)) begin
            st   <= ST_CONV;
            tcnt <= '0;
            bidx <= IDX_W'(RES_W - 1);
            sar  <= MID_CODE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (tcnt == CNT_W'(BIT_CYC - 1)) begin
            tcnt <= '0;
            sar  <= sar_nxt;
            if (bidx == '0) begin
              st    <= ST_READ;
              bidx  <= IDX_W'(RES_W - 1);
              rcnt  <= '0;
              armed <= 1'b0;
            end else begin
              bidx <= bidx - 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_READ: begin
          if (sk_rise) begin
            armed <= 1'b1;
            rcnt  <= rcnt + 1'b1;
            if (rcnt == RCNT_W'(RES_W - 1)) begin
              st <= ST_IDLE;
              ch <= 1'b0;
            end
          end else if (sk_fall && armed) begin
            armed <= 1'b0;
            if (bidx != '0) bidx <= bidx - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign dac_code_o = sar;
  assign ch_sel_o   = ch;
  assign pwr_en_o   = (st == ST_ACQ) || (st == ST_CONV);
  assign sdo_oe_o   = (st != ST_IDLE);
  assign sdo_o      = (st == ST_READ) ? sar[bidx] : 1'b0;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RES_W-1:0] dac_code_o,
  input logic             ch_sel_o,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic             pwr_en_o
);
  localparam logic [RES_W-1:0] MID_CODE = {1'b1, {(RES_W-1){1'b0}}};

  assert_dout_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en_o |-> (sdo_oe_o && !sdo_o));

  assert_msb_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en_o) |-> (sdo_oe_o && sdo_o == dac_code_o[RES_W-1]));

  assert_result_static_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!pwr_en_o) && !pwr_en_o) |-> $stable(dac_code_o));

  assert_start_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |-> (dac_code_o == MID_CODE));

  assert_ch1_when_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_sel_o) |-> pwr_en_o);

  assert_ch0_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch_sel_o) |-> !sdo_oe_o);
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code_o(dac_code_o), .ch_sel_o(ch_sel_o),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .pwr_en_o(pwr_en_o)
);

// File: tb/sim_sar_adc_seq.sv
module sim_sar_adc_seq;
  localparam int ACQ  = 16;
  localparam int BITC = 4;
  localparam int CONV = ACQ + 8 * BITC;

  logic clk = 1'b0, rst_n = 1'b0, cnvst = 1'b0, sclk = 1'b0;
  logic [7:0] vin0 = 8'h00, vin1 = 8'h00;
  logic [7:0] dac_code;
  logic ch_sel, sdo, sdo_oe, pwr_en;
  logic cmp;

  int checks = 0, fails = 0, cyc = 0;

  assign cmp = ((ch_sel ? vin1 : vin0) >= dac_code);

  always #10 clk = ~clk;

  sar_adc_seq #(.ACQ_CYC(ACQ), .BIT_CYC(BITC), .RES_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cnvst_i(cnvst), .sclk_i(sclk), .cmp_ge_i(cmp),
    .dac_code_o(dac_code), .ch_sel_o(ch_sel), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .pwr_en_o(pwr_en)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 acquire, 2 trials, 3 readout
  int m_ph = 0, m_cnt = 0, m_bit = 7, m_rises = 0;
  bit m_ch = 0, m_armed = 0, cf, sr, sf;
  logic [7:0] m_code = 8'h00, m_in;
  bit [2:0] hc = '0, hs = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_bit = 7; m_rises = 0;
      m_ch = 0; m_armed = 0; m_code = 8'h00; hc = '0; hs = '0;
    end else begin
      cf = hc[2] && !hc[1];
      sr = !hs[2] && hs[1];
      sf = hs[2] && !hs[1];
      hc = {hc[1:0], cnvst};
      hs = {hs[1:0], sclk};
      if (cf) begin
        if (m_ph == 1 || m_ph == 2) m_ch = 1;
        m_ph = 1; m_cnt = 0; m_code = 8'h80;
      end else if (m_ph == 1) begin
        m_cnt++;
        if (m_cnt == ACQ) begin m_ph = 2; m_cnt = 0; m_bit = 7; m_code = 8'h80; end
      end else if (m_ph == 2) begin
        m_cnt++;
        if (m_cnt == BITC) begin
          m_cnt = 0;
          m_in = m_ch ? vin1 : vin0;
          if (m_in < m_code) m_code[m_bit] = 1'b0;
          if (m_bit > 0) m_code[m_bit-1] = 1'b1;
          if (m_bit == 0) begin m_ph = 3; m_bit = 7; m_rises = 0; m_armed = 0; end
          else m_bit--;
        end
      end else if (m_ph == 3) begin
        if (sr) begin
          m_armed = 1; m_rises++;
          if (m_rises == 8) begin m_ph = 0; m_ch = 0; end
        end else if (sf && m_armed) begin
          m_armed = 0;
          if (m_bit > 0) m_bit--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(pwr_en == (m_ph == 1 || m_ph == 2), "R6", "model pwr_en", pwr_en, (m_ph == 1 || m_ph == 2));
      chk(sdo_oe == (m_ph != 0), "R8", "model sdo_oe", sdo_oe, (m_ph != 0));
      chk(sdo == ((m_ph == 3) ? m_code[m_bit] : 1'b0), (m_ph == 3) ? "R7" : "R4", "model sdo",
          sdo, (m_ph == 3) ? m_code[m_bit] : 1'b0);
      chk(ch_sel == m_ch, "R3", "model ch_sel", ch_sel, m_ch);
      chk(dac_code == m_code, "R5", "model dac_code", dac_code, m_code);
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_byte(input bit idle_high, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (idle_high) begin
        sclk = 1'b0; w(3); b[7-i] = sdo; sclk = 1'b1; w(3);
      end else begin
        b[7-i] = sdo; sclk = 1'b1; w(3); sclk = 1'b0; w(3);
      end
    end
  endtask

  task automatic start_conv();
    cnvst = 1'b0; w(3); cnvst = 1'b1; w(2);
  endtask

  logic [7:0] got;

  initial begin
    w(4);
    rst_n = 1'b1;
    w(1);
    chk(!sdo_oe && !pwr_en && !ch_sel && dac_code == 8'h00, "R1", "reset outputs",
        {sdo_oe, pwr_en, ch_sel}, 0);

    w(20);
    chk(!pwr_en, "R9", "low at reset starts nothing", pwr_en, 0);
    cnvst = 1'b1; w(10);
    chk(!pwr_en, "R9", "rising edge starts nothing", pwr_en, 0);

    // plain conversion, sclk idle low, sclk noise during conversion
    vin0 = 8'hA5;
    cnvst = 1'b0; w(2);
    chk(!pwr_en, "R2", "no power before third edge", pwr_en, 0);
    w(1);
    chk(pwr_en && sdo_oe && !sdo && !ch_sel, "R2", "start on channel 0",
        {pwr_en, sdo_oe, sdo, ch_sel}, 4'b1100);
    cnvst = 1'b1;
    for (int k = 0; k < 2; k++) begin sclk = 1'b1; w(3); sclk = 1'b0; w(3); end
    chk(pwr_en && !sdo, "R4", "busy, sdo low", {pwr_en, sdo}, 2'b10);
    w(CONV);
    chk(!pwr_en && sdo_oe && sdo == 1'b1, "R6", "msb ready without sclk",
        {pwr_en, sdo_oe, sdo}, 3'b011);
    read_byte(1'b0, got);
    chk(got == 8'hA5, "R5", "result A5 idle low", got, 8'hA5);
    chk(!sdo_oe && !ch_sel, "R8", "released after 8 rises", {sdo_oe, ch_sel}, 0);

    // full scale, sclk idle high
    vin0 = 8'hFF; sclk = 1'b1; w(5);
    start_conv(); w(CONV + 5);
    read_byte(1'b1, got);
    chk(got == 8'hFF, "R7", "full scale idle high", got, 8'hFF);
    chk(!sdo_oe, "R8", "idle high release", sdo_oe, 0);
    sclk = 1'b0; w(5);

    // abort and restart on channel 1
    vin0 = 8'h11; vin1 = 8'h3C;
    cnvst = 1'b0; w(5); cnvst = 1'b1; w(5); cnvst = 1'b0; w(3);
    chk(ch_sel && pwr_en, "R3", "abort selects channel 1", {ch_sel, pwr_en}, 2'b11);
    cnvst = 1'b1; w(CONV - 6);
    chk(pwr_en, "R3", "conversion restarted", pwr_en, 1);
    w(10);
    chk(!pwr_en && sdo == 1'b0, "R6", "ch1 msb", {pwr_en, sdo}, 0);

    // start while readout pending keeps channel 1
    cnvst = 1'b0; w(3);
    chk(ch_sel && pwr_en && sdo_oe && !sdo, "R10", "restart keeps channel",
        {ch_sel, pwr_en, sdo_oe, sdo}, 4'b1110);
    cnvst = 1'b1; w(CONV + 5);
    read_byte(1'b0, got);
    chk(got == 8'h3C, "R3", "channel 1 result", got, 8'h3C);
    chk(!ch_sel, "R8", "channel back to 0", ch_sel, 0);

    // long hold before read
    vin0 = 8'h5A; start_conv(); w(CONV + 5);
    w(2000); vin0 = 8'h00;
    chk(dac_code == 8'h5A, "R6", "result held", dac_code, 8'h5A);
    read_byte(1'b0, got);
    chk(got == 8'h5A, "R6", "late read", got, 8'h5A);

    // zero scale
    start_conv(); w(CONV + 5);
    read_byte(1'b0, got);
    chk(got == 8'h00, "R5", "zero scale", got, 8'h00);

    // start edge on the last trial cycle: restart wins
    vin0 = 8'h77; vin1 = 8'hC3;
    cnvst = 1'b0; w(5); cnvst = 1'b1; w(CONV - 5); cnvst = 1'b0; w(2);
    chk(pwr_en, "R3", "no drop at collision", pwr_en, 1);
    w(1);
    chk(pwr_en && ch_sel, "R3", "collision restarts on ch1", {pwr_en, ch_sel}, 2'b11);
    cnvst = 1'b1; w(CONV + 5);
    read_byte(1'b0, got);
    chk(got == 8'hC3, "R3", "collision result from ch1", got, 8'hC3);

    w(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule